// File: doc/BRIEF.md
# Partition Interconnect Isolation Gate

This block decides, for each of a small number of chip partitions, whether that partition is attached to the system interconnect. Software reaches it over a plain 32-bit register bus. The bus has a select, a write strobe, a byte address, write data, and read data that is returned combinationally in the same cycle. Each partition owns two words. The first is a control word that carries a disable request and a write-unlock flag. The second is a read-only status word that reports whether the partition is actually cut off.

A control word only takes a new disable request when it is unlocked, or when the write itself raises the unlock flag. When the disable request changes, the isolation state does not follow at once. It follows after a fixed acknowledge latency. The status bit and the isolation output both report this delayed state.

A driver brings a partition online in four steps. It raises the unlock flag, clears the disable request, polls the status word until the isolation bit reads 0, and then clears the unlock flag again. Out of reset, partition 0 is attached and every other partition is isolated and locked.

Top module: `pig_gate`

## Requirements
- R1: The control word of partition p is at byte address 4*p. Its status word is at 0x80 + 4*p, for p below NUM_PARTS. A read of any other address returns 0. A write to any other address changes no register.
- R2: A control word reads back the unlock flag in bit 31 and the disable request in bit 3. Every other bit reads 0, whatever was written there.
- R3: A write to a locked control word whose bit 31 is 0 is ignored. Both the unlock flag and the disable request keep their values.
- R4: A write to a control word that is unlocked, or whose bit 31 is 1, loads the unlock flag from bit 31 and the disable request from bit 3. A write of 0 to an unlocked word therefore locks it again.
- R5: A status word reads the partition's isolation state in bit 4 and 0 in every other bit. A write to a status address has no effect.
- R6: The isolation state equals the disable request as it stood ACK_LAT clock edges earlier (default 3). A request that is held for a single cycle is reproduced for a single cycle, delayed by the same amount.
- R7: Reset is synchronous and active high. After reset, partition 0 has control 0x00000000 and status 0. Every other partition has control 0x00000008 (isolated, locked) and status 0x00000010.
- R8: iso_o[p] is 1 exactly when partition p's status bit 4 reads 1.
- R9: A write to one partition's control word leaves every other partition's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| iso_o | output | NUM_PARTS | Per-partition isolation, 1 = detached from interconnect |

## Verification
The hardest case to reach from the ports is a disable request that changes again while an earlier change is still travelling through the acknowledge delay. Normal driver code never does this, because it always waits for the status bit before writing again. The stimulus reaches the case with two writes to one partition in back-to-back cycles. The first raises the unlock flag and clears the request in a single write. The second sets the request again. The isolation output is then sampled on each following cycle, and it must show a one-cycle window of 0 at exactly the latency offset. A write to a locked word without bit 31 must also be shown to have no effect. This is checked by reading the control word back and by later reads of the status word.

// File: rtl/pig_pkg.sv
package pig_pkg;

    localparam int UNLOCK_BIT = 31;
    localparam int DIS_BIT    = 3;
    localparam int STAT_BIT   = 4;
    localparam int STAT_BASE  = 'h80;
    localparam int WORD_BYTES = 4;

    typedef struct packed {
        logic unlock;
        logic dis;
    } ctrl_t;

    function automatic ctrl_t ctrl_reset(input logic dis_at_reset);
        ctrl_t c;
        c.unlock = 1'b0;
        c.dis    = dis_at_reset;
        return c;
    endfunction

    function automatic logic write_allowed(input ctrl_t cur, input logic wr_unlock);
        return cur.unlock | wr_unlock;
    endfunction

    function automatic logic [31:0] ctrl_word(input ctrl_t c);
        logic [31:0] w;
        w             = '0;
        w[UNLOCK_BIT] = c.unlock;
        w[DIS_BIT]    = c.dis;
        return w;
    endfunction

    function automatic logic [31:0] stat_word(input logic isolated);
        logic [31:0] w;
        w           = '0;
        w[STAT_BIT] = isolated;
        return w;
    endfunction

endpackage

// File: rtl/pig_decode.sv
module pig_decode
    import pig_pkg::*;
#(
    parameter int unsigned NUM_PARTS = 4,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_PARTS-1:0] ctrl_hit,
    output logic [NUM_PARTS-1:0] stat_hit
);

    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_hit
        localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(p * WORD_BYTES);
        localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_BASE + p * WORD_BYTES);
        assign ctrl_hit[p] = (addr == CTRL_ADDR);
        assign stat_hit[p] = (addr == STAT_ADDR);
    end

endmodule

// File: rtl/pig_ctrl_reg.sv
module pig_ctrl_reg
    import pig_pkg::*;
#(
    parameter logic RST_DIS = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  wr_unlock,
    input  logic  wr_dis,
    output ctrl_t ctrl_o
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_reset(RST_DIS);
        end else if (wr_en && write_allowed(ctrl_q, wr_unlock)) begin
            ctrl_q.unlock <= wr_unlock;
            ctrl_q.dis    <= wr_dis;
        end
    end

    assign ctrl_o = ctrl_q;

    // R3: locked word, write without unlock bit -> nothing moves
    a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ctrl_o.unlock && !wr_unlock) |=> $stable(ctrl_o));

    // R4: accepted write loads both fields
    a_r4_write_accepted: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (ctrl_o.unlock || wr_unlock)) |=>
        (ctrl_o.unlock == $past(wr_unlock) && ctrl_o.dis == $past(wr_dis)));

    // R7: value right after reset
    a_r7_reset_value: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ctrl_o.unlock && ctrl_o.dis == RST_DIS));

endmodule

// File: rtl/pig_ack_delay.sv
module pig_ack_delay #(
    parameter int unsigned LAT     = 3,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic stat_o
);

    if (LAT <= 1) begin : g_single
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= RST_VAL;
            else     q <= req_i;
        end
        assign stat_o = q;
    end else begin : g_line
        logic [LAT-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= {LAT{RST_VAL}};
            else     pipe <= {pipe[LAT-2:0], req_i};
        end
        assign stat_o = pipe[LAT-1];
    end

    // Checker: cycles since the request last changed, saturating at LAT
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] LAT_C = CW'(LAT);
    logic [CW-1:0] since_chg;
    logic          last_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_chg <= LAT_C;
            last_req  <= RST_VAL;
        end else begin
            last_req <= req_i;
            if (req_i != last_req)   since_chg <= CW'(1);
            else if (since_chg < LAT_C) since_chg <= since_chg + CW'(1);
        end
    end

    // R6: once a request has been steady for LAT edges, status has caught up
    a_r6_status_settled: assert property (@(posedge clk) disable iff (rst)
        (since_chg == LAT_C && req_i == last_req) |-> (stat_o == req_i));

endmodule

// File: rtl/pig_gate.sv
module pig_gate
    import pig_pkg::*;
#(
    parameter int unsigned NUM_PARTS = 4,
    parameter int unsigned ACK_LAT   = 3,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_PARTS-1:0] iso_o
);

    logic [NUM_PARTS-1:0] ctrl_hit;
    logic [NUM_PARTS-1:0] stat_hit;
    ctrl_t                ctrl_q [NUM_PARTS];
    logic [NUM_PARTS-1:0] stat_q;
    logic                 wr_cycle;
    logic                 rd_cycle;
    logic                 unused_wdata_bits;

    assign wr_cycle = bus_sel && bus_we;
    assign rd_cycle = bus_sel && !bus_we;
    assign unused_wdata_bits = ^{bus_wdata[30:4], bus_wdata[2:0]};

    pig_decode #(
        .NUM_PARTS (NUM_PARTS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr     (bus_addr),
        .ctrl_hit (ctrl_hit),
        .stat_hit (stat_hit)
    );

    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
        localparam logic RST_DIS = (p != 0) ? 1'b1 : 1'b0;

        pig_ctrl_reg #(
            .RST_DIS (RST_DIS)
        ) u_ctrl (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_cycle && ctrl_hit[p]),
            .wr_unlock (bus_wdata[UNLOCK_BIT]),
            .wr_dis    (bus_wdata[DIS_BIT]),
            .ctrl_o    (ctrl_q[p])
        );

        pig_ack_delay #(
            .LAT     (ACK_LAT),
            .RST_VAL (RST_DIS)
        ) u_ack (
            .clk    (clk),
            .rst    (rst),
            .req_i  (ctrl_q[p].dis),
            .stat_o (stat_q[p])
        );

        assign iso_o[p] = stat_q[p];

        // R8: status read and isolation output agree
        a_r8_status_matches_iso: assert property (@(posedge clk) disable iff (rst)
            (rd_cycle && stat_hit[p]) |-> (bus_rdata[STAT_BIT] == iso_o[p]));

        // R9: writes aimed elsewhere leave this partition alone
        a_r9_partition_independent: assert property (@(posedge clk) disable iff (rst)
            !(wr_cycle && ctrl_hit[p]) |=> $stable(ctrl_q[p]));
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_cycle) begin
            for (int p = 0; p < NUM_PARTS; p++) begin
                if (ctrl_hit[p]) bus_rdata = bus_rdata | ctrl_word(ctrl_q[p]);
                if (stat_hit[p]) bus_rdata = bus_rdata | stat_word(stat_q[p]);
            end
        end
    end

endmodule

// File: tb/pig_gate_test.sv
module pig_gate_test;

    localparam int NP = 4;
    localparam int LAT = 3;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] expv;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h04, 32'h0,        32'h00000008, 8'd7}, // R7 p1 reset
        '{1'b1, 8'h04, 32'h0,        32'h0,        8'd3}, // R3 locked write
        '{1'b0, 8'h04, 32'h0,        32'h00000008, 8'd3},
        '{1'b0, 8'h84, 32'h0,        32'h00000010, 8'd3},
        '{1'b1, 8'h04, 32'h80000008, 32'h0,        8'd4}, // R4 unlock
        '{1'b0, 8'h04, 32'h0,        32'h80000008, 8'd4},
        '{1'b1, 8'h04, 32'h80000000, 32'h0,        8'd6}, // R6 clear request
        '{1'b0, 8'h84, 32'h0,        32'h00000010, 8'd6},
        '{1'b0, 8'h84, 32'h0,        32'h00000010, 8'd6},
        '{1'b0, 8'h84, 32'h0,        32'h00000010, 8'd6},
        '{1'b0, 8'h84, 32'h0,        32'h00000000, 8'd6}, // R6 after LAT edges
        '{1'b1, 8'h04, 32'h0,        32'h0,        8'd4}, // R4 relock
        '{1'b0, 8'h04, 32'h0,        32'h00000000, 8'd4},
        '{1'b1, 8'h04, 32'h00000008, 32'h0,        8'd3}, // R3 locked again
        '{1'b0, 8'h04, 32'h0,        32'h00000000, 8'd3},
        '{1'b0, 8'h84, 32'h0,        32'h00000000, 8'd3},
        '{1'b1, 8'h08, 32'h80000000, 32'h0,        8'd4}, // R4 unlock in same write
        '{1'b0, 8'h08, 32'h0,        32'h80000000, 8'd4},
        '{1'b0, 8'h0C, 32'h0,        32'h00000008, 8'd9}, // R9
        '{1'b0, 8'h00, 32'h0,        32'h00000000, 8'd7}, // R7 p0
        '{1'b1, 8'h80, 32'hFFFFFFFF, 32'h0,        8'd5}, // R5 status write
        '{1'b0, 8'h80, 32'h0,        32'h00000000, 8'd5},
        '{1'b0, 8'h40, 32'h0,        32'h00000000, 8'd1}, // R1 unmapped
        '{1'b1, 8'h40, 32'h80000008, 32'h0,        8'd1},
        '{1'b0, 8'h0C, 32'h0,        32'h00000008, 8'd1},
        '{1'b0, 8'h08, 32'h0,        32'h80000000, 8'd1},
        '{1'b1, 8'h00, 32'h8000FFFF, 32'h0,        8'd2}, // R2 masking
        '{1'b0, 8'h00, 32'h0,        32'h80000008, 8'd2},
        '{1'b0, 8'h88, 32'h0,        32'h00000000, 8'd6},
        '{1'b0, 8'h8C, 32'h0,        32'h00000010, 8'd5}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_sel;
    logic          bus_we;
    logic [7:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] iso_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pig_gate #(.NUM_PARTS(NP), .ACK_LAT(LAT), .ADDR_W(8)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .iso_o(iso_o)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp_v,
                         input string what);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp_v);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        step();
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R7 reset isolation pattern
        #1 check(7, 32'(iso_o), 32'h0000000E, "iso after reset");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) begin
                do_write(VECS[i].addr, VECS[i].data);
            end else begin
                do_read(VECS[i].addr, rd);
                check(int'(VECS[i].req), rd, VECS[i].expv,
                      $sformatf("vector %0d addr %h", i, VECS[i].addr));
            end
        end

        // R8: let p0 settle, then compare outputs with status reads
        repeat (LAT + 1) step();
        #1 check(8, 32'(iso_o), 32'h00000009, "iso pattern");
        for (int p = 0; p < NP; p++) begin
            do_read(8'(8'h80 + 4 * p), rd);
            check(8, 32'(rd[4]), 32'(iso_o[p]), $sformatf("status bit vs iso p%0d", p));
        end

        // R6: one-cycle request pulse on p3 is reproduced after LAT edges
        do_write(8'h0C, 32'h80000000);
        do_write(8'h0C, 32'h80000008);
        #1 check(6, 32'(iso_o[3]), 32'h1, "pulse k1");
        step();
        #1 check(6, 32'(iso_o[3]), 32'h1, "pulse k2");
        step();
        #1 check(6, 32'(iso_o[3]), 32'h0, "pulse k3");
        step();
        #1 check(6, 32'(iso_o[3]), 32'h1, "pulse k4");

        // R7: reset in mid-run restores all defaults
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        #1 check(7, 32'(iso_o), 32'h0000000E, "iso after second reset");
        for (int p = 0; p < NP; p++) begin
            do_read(8'(4 * p), rd);
            check(7, rd, (p == 0) ? 32'h0 : 32'h00000008, $sformatf("ctrl p%0d after reset", p));
            do_read(8'(8'h80 + 4 * p), rd);
            check(7, rd, (p == 0) ? 32'h0 : 32'h00000010, $sformatf("stat p%0d after reset", p));
        end

        finish_run();
    end

endmodule